// File: doc/BRIEF.md
# ATA Exception Classifier

This block sits beside the host side of an ATA/ATAPI register-level command engine. Each time the engine samples the device status, it presents the current protocol phase, the command kind, the status and error register bytes, the system bus DMA error bit and a timeout qualifier, and pulses a sample strobe. The classifier decides whether that sample is abnormal. If it is, the classifier sorts it into exactly one exception category, so that recovery software can pick its action without decoding the raw bits again.

The category is driven as a one-hot vector. Three recovery hints are derived from it:
- a reset request,
- a transport-suspect hint, which proposes lowering the link speed,
- an error-log fetch request, used for queued commands.

The result is captured one clock after the strobe. It stays frozen until the recovery logic acknowledges it, so the first abnormal event in a burst is the one that gets reported.

Top module: `ata_exc_classifier`

## Requirements
- R1: After reset, and whenever nothing is held, the category vector and all three hints are zero. The category vector never has more than one bit set. Category bits are: 0 protocol violation, 1 other device error, 2 check condition, 3 media error, 4 address error, 5 transfer CRC error, 6 queued-command error, 7 system bus error, 8 late completion, 9 unknown timeout.
- R2: In phase 0 (before issue), a protocol violation is reported for any status other than BSY (bit 7) clear, DRDY (bit 6) set and DRQ (bit 3) clear. A status that meets that condition reports nothing.
- R3: In phase 4 (PIO data), BSY clear with DRQ clear is a protocol violation. In phase 5 (completion), BSY clear with DRQ set is a protocol violation.
- R4: In phase 1 (packet just issued), BSY clear with ERR (bit 0) set reports "other device error" when ABRT (error bit 2) is set, and a protocol violation when ABRT is clear. In phase 2 (CDB transfer), BSY clear with ERR set is a protocol violation.
- R5: In phase 3 (after the last CDB byte), BSY clear with ERR set is a check condition, whatever ABRT holds. The same applies in phase 5 when the command kind is 1 (packet). While BSY is set, nothing is reported.
- R6: In phases 4 and 5 for command kinds other than packet, BSY clear with ERR set is decoded from the error byte. The decode, in falling priority, is: ICRC (bit 7) gives transfer CRC error, UNC (bit 6) gives media error, IDNF (bit 4) gives address error, and anything else gives other device error.
- R7: In phase 6 (queued commands outstanding), BSY clear with ERR set reports a queued-command error and raises the log-fetch hint.
- R8: A sample with the DMA error input set reports a system bus error and raises only the reset hint.
- R9: A sample with the timeout qualifier set reports a late completion (reset hint only) when the done flag is set. With the done flag clear, it reports an unknown timeout (reset and transport-suspect hints).
- R10: A protocol violation raises the reset and transport-suspect hints. A transfer CRC error raises only the transport-suspect hint. Check condition, media, address and other device errors raise no hint.
- R11: When several conditions hold at once, the order of precedence is: system bus error, then protocol violation, then timeout, then any device-reported category.
- R12: The category appears on the clock edge after the strobe. While a category is held, further strobes are ignored. An acknowledge clears the held result on the next edge, and a strobe in that same cycle is also ignored.
- R13: Phase 7 is reserved. A sample in it reports nothing unless the DMA error or timeout qualifier is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | 1 | Status sample strobe |
| phase_i | input | 3 | Protocol phase code (0..7 as in the requirements) |
| cmd_kind_i | input | 2 | Command kind: 0 ATA, 1 packet, 2 queued |
| status_i | input | 8 | Device status byte |
| error_i | input | 8 | Device error byte |
| dma_err_i | input | 1 | System bus DMA error bit |
| tmo_i | input | 1 | Sample is a timeout |
| late_done_i | input | 1 | Timed-out command found complete |
| ack_i | input | 1 | Acknowledge and release held result |
| cat_o | output | 10 | One-hot exception category |
| reset_req_o | output | 1 | Reset needed |
| xport_suspect_o | output | 1 | Link transmission suspected |
| fetch_log_o | output | 1 | Queued-error log fetch needed |

## Verification
The bench targets the places where the same status bits mean different things.

- ERR in phase 1, 2 and 3 must give three different answers. A design keyed only on bits would call a CDB-time error a check condition.
- ICRC together with ABRT, and UNC together with IDNF, check the decode order. A swapped priority would report "other" or "address" instead.
- Combined DMA error, protocol violation and timeout samples expose any reordering of the precedence chain.
- A second strobe while a result is held, and a strobe in the same cycle as the acknowledge, catch a design that overwrites the first event or reloads on release.

// File: rtl/ata_exc_pkg.sv
package ata_exc_pkg;
  localparam int NCAT = 10;

  typedef enum logic [2:0] {
    PH_ISSUE      = 3'd0,
    PH_PKT_ISSUED = 3'd1,
    PH_CDB_XFER   = 3'd2,
    PH_CDB_DONE   = 3'd3,
    PH_PIO_DATA   = 3'd4,
    PH_COMPLETE   = 3'd5,
    PH_NCQ_PEND   = 3'd6,
    PH_RSVD       = 3'd7
  } phase_e;

  localparam logic [1:0] CK_PACKET = 2'd1;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;
  localparam int ER_ICRC = 7;
  localparam int ER_UNC  = 6;
  localparam int ER_IDNF = 4;
  localparam int ER_ABRT = 2;

  localparam int C_HSM    = 0;
  localparam int C_DEVOTH = 1;
  localparam int C_CHK    = 2;
  localparam int C_MEDIA  = 3;
  localparam int C_ADDR   = 4;
  localparam int C_CRC    = 5;
  localparam int C_NCQ    = 6;
  localparam int C_SYSBUS = 7;
  localparam int C_LATE   = 8;
  localparam int C_TMO    = 9;

  localparam logic [NCAT-1:0] MASK_RESET =
    NCAT'((1 << C_HSM) | (1 << C_SYSBUS) | (1 << C_LATE) | (1 << C_TMO));
  localparam logic [NCAT-1:0] MASK_XPORT =
    NCAT'((1 << C_HSM) | (1 << C_CRC) | (1 << C_TMO));
  localparam logic [NCAT-1:0] MASK_FETCH = NCAT'(1 << C_NCQ);
endpackage

// File: rtl/ata_hsm_check.sv
module ata_hsm_check
  import ata_exc_pkg::*;
(
  input  logic [2:0] phase_i,
  input  logic [7:0] status_i,
  input  logic [7:0] error_i,
  output logic       viol_o
);
  logic idle_n, drdy, drq, err, abrt;

  always_comb begin
    idle_n = status_i[ST_BSY];
    drdy   = status_i[ST_DRDY];
    drq    = status_i[ST_DRQ];
    err    = status_i[ST_ERR];
    abrt   = error_i[ER_ABRT];
    viol_o = 1'b0;
    unique case (phase_e'(phase_i))
      PH_ISSUE:      viol_o = !(!idle_n && drdy && !drq);
      PH_PKT_ISSUED: viol_o = !idle_n && err && !abrt;
      PH_CDB_XFER:   viol_o = !idle_n && err;
      PH_PIO_DATA:   viol_o = !idle_n && !drq;
      PH_COMPLETE:   viol_o = !idle_n && drq;
      default:       viol_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ata_dev_decode.sv
module ata_dev_decode
  import ata_exc_pkg::*;
(
  input  logic [2:0]      phase_i,
  input  logic [1:0]      cmd_kind_i,
  input  logic [7:0]      status_i,
  input  logic [7:0]      error_i,
  output logic [NCAT-1:0] cat_o
);
  logic            done_err;
  logic [NCAT-1:0] ata_cat;

  always_comb begin
    ata_cat = '0;
    if (error_i[ER_ICRC])      ata_cat[C_CRC]    = 1'b1;
    else if (error_i[ER_UNC])  ata_cat[C_MEDIA]  = 1'b1;
    else if (error_i[ER_IDNF]) ata_cat[C_ADDR]   = 1'b1;
    else                       ata_cat[C_DEVOTH] = 1'b1;
  end

  always_comb begin
    done_err = !status_i[ST_BSY] && status_i[ST_ERR];
    cat_o    = '0;
    if (done_err) begin
      unique case (phase_e'(phase_i))
        PH_PKT_ISSUED: cat_o[C_DEVOTH] = error_i[ER_ABRT];
        PH_CDB_DONE:   cat_o[C_CHK]    = 1'b1;
        PH_PIO_DATA:   cat_o           = ata_cat;
        PH_COMPLETE:   if (cmd_kind_i == CK_PACKET) cat_o[C_CHK] = 1'b1;
                       else cat_o = ata_cat;
        PH_NCQ_PEND:   cat_o[C_NCQ]    = 1'b1;
        default:       cat_o           = '0;
      endcase
    end
  end
endmodule

// File: rtl/ata_exc_merge.sv
module ata_exc_merge
  import ata_exc_pkg::*;
(
  input  logic            dma_err_i,
  input  logic            hsm_viol_i,
  input  logic            tmo_i,
  input  logic            late_done_i,
  input  logic [NCAT-1:0] dev_cat_i,
  output logic [NCAT-1:0] cat_o
);
  always_comb begin
    cat_o = '0;
    if (dma_err_i)       cat_o[C_SYSBUS] = 1'b1;
    else if (hsm_viol_i) cat_o[C_HSM]    = 1'b1;
    else if (tmo_i) begin
      if (late_done_i)   cat_o[C_LATE]   = 1'b1;
      else               cat_o[C_TMO]    = 1'b1;
    end
    else                 cat_o           = dev_cat_i;
  end
endmodule

// File: rtl/ata_exc_classifier.sv
module ata_exc_classifier
  import ata_exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  input  logic [2:0]      phase_i,
  input  logic [1:0]      cmd_kind_i,
  input  logic [7:0]      status_i,
  input  logic [7:0]      error_i,
  input  logic            dma_err_i,
  input  logic            tmo_i,
  input  logic            late_done_i,
  input  logic            ack_i,
  output logic [NCAT-1:0] cat_o,
  output logic            reset_req_o,
  output logic            xport_suspect_o,
  output logic            fetch_log_o
);
  logic            rst_meta, rst_sync_n;
  logic            hsm_viol;
  logic [NCAT-1:0] dev_cat, nxt_cat;
  logic [NCAT-1:0] cat_q, cat_d;
  logic            held, cap_en, clr_en, cat_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ata_hsm_check u_hsm (
    .phase_i (phase_i),
    .status_i(status_i),
    .error_i (error_i),
    .viol_o  (hsm_viol)
  );

  ata_dev_decode u_dev (
    .phase_i   (phase_i),
    .cmd_kind_i(cmd_kind_i),
    .status_i  (status_i),
    .error_i   (error_i),
    .cat_o     (dev_cat)
  );

  ata_exc_merge u_merge (
    .dma_err_i  (dma_err_i),
    .hsm_viol_i (hsm_viol),
    .tmo_i      (tmo_i),
    .late_done_i(late_done_i),
    .dev_cat_i  (dev_cat),
    .cat_o      (nxt_cat)
  );

  always_comb begin
    held   = |cat_q;
    clr_en = held && ack_i;
    cap_en = sample_i && !held;
    cat_en = clr_en || cap_en;
    cat_d  = cat_q;
    if (clr_en)      cat_d = '0;
    else if (cap_en) cat_d = nxt_cat;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cat_q <= '0;
    else if (cat_en)  cat_q <= cat_d;
  end

  assign cat_o           = cat_q;
  assign reset_req_o     = |(cat_q & MASK_RESET);
  assign xport_suspect_o = |(cat_q & MASK_XPORT);
  assign fetch_log_o     = |(cat_q & MASK_FETCH);

  AST_CAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(cat_o)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held && !ack_i) |=> $stable(cat_o)); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held && ack_i) |=> (cat_o == '0)); // R12
  AST_SYSBUS_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_i && !held && dma_err_i) |=> (cat_o[C_SYSBUS] && reset_req_o)); // R8
  AST_HSM_HINTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cat_o[C_HSM] |-> (reset_req_o && xport_suspect_o && !fetch_log_o)); // R10
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_i && !held && phase_i == 3'd7 && !dma_err_i && !tmo_i) |=> (cat_o == '0)); // R13
  AST_FETCH_NCQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_log_o |-> cat_o[C_NCQ]); // R7
endmodule

// File: tb/tb_ata_exc_classifier.sv
module tb_ata_exc_classifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_i, dma_err_i, tmo_i, late_done_i, ack_i;
  logic [2:0] phase_i;
  logic [1:0] cmd_kind_i;
  logic [7:0] status_i, error_i;
  logic [9:0] cat_o;
  logic       reset_req_o, xport_suspect_o, fetch_log_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  ata_exc_classifier dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .phase_i(phase_i),
    .cmd_kind_i(cmd_kind_i), .status_i(status_i), .error_i(error_i),
    .dma_err_i(dma_err_i), .tmo_i(tmo_i), .late_done_i(late_done_i),
    .ack_i(ack_i), .cat_o(cat_o), .reset_req_o(reset_req_o),
    .xport_suspect_o(xport_suspect_o), .fetch_log_o(fetch_log_o)
  );

  // {req[4], phase[3], kind[2], status[8], error[8], dma, tmo, late, cat[10], flags{fetch,xport,reset}}
  localparam int NV = 24;
  localparam logic [40:0] VEC [NV] = '{
    {4'd2,  3'd0, 2'd0, 8'h40, 8'h00, 3'b000, 10'h000, 3'b000}, // R2 clean issue
    {4'd2,  3'd0, 2'd0, 8'h80, 8'h00, 3'b000, 10'h001, 3'b011}, // R2 busy at issue
    {4'd2,  3'd0, 2'd0, 8'h48, 8'h00, 3'b000, 10'h001, 3'b011}, // R2 drq at issue
    {4'd3,  3'd4, 2'd0, 8'h40, 8'h00, 3'b000, 10'h001, 3'b011}, // R3 pio no drq
    {4'd6,  3'd4, 2'd0, 8'h49, 8'h40, 3'b000, 10'h008, 3'b000}, // R6 pio media
    {4'd3,  3'd5, 2'd0, 8'h48, 8'h00, 3'b000, 10'h001, 3'b011}, // R3 drq at completion
    {4'd10, 3'd5, 2'd0, 8'h41, 8'h80, 3'b000, 10'h020, 3'b010}, // R10 crc hint
    {4'd6,  3'd5, 2'd0, 8'h41, 8'h10, 3'b000, 10'h010, 3'b000}, // R6 address
    {4'd6,  3'd5, 2'd0, 8'h41, 8'h04, 3'b000, 10'h002, 3'b000}, // R6 abort other
    {4'd6,  3'd5, 2'd0, 8'h41, 8'h84, 3'b000, 10'h020, 3'b010}, // R6 icrc over abrt
    {4'd6,  3'd5, 2'd0, 8'h41, 8'h50, 3'b000, 10'h008, 3'b000}, // R6 unc over idnf
    {4'd4,  3'd1, 2'd1, 8'h41, 8'h04, 3'b000, 10'h002, 3'b000}, // R4 packet unsupported
    {4'd4,  3'd1, 2'd1, 8'h41, 8'h00, 3'b000, 10'h001, 3'b011}, // R4 early error
    {4'd4,  3'd2, 2'd1, 8'h41, 8'h04, 3'b000, 10'h001, 3'b011}, // R4 cdb error
    {4'd5,  3'd3, 2'd1, 8'h41, 8'h04, 3'b000, 10'h004, 3'b000}, // R5 chk with abrt
    {4'd5,  3'd3, 2'd1, 8'h41, 8'h00, 3'b000, 10'h004, 3'b000}, // R5 chk
    {4'd5,  3'd3, 2'd1, 8'hC1, 8'h00, 3'b000, 10'h000, 3'b000}, // R5 busy ignored
    {4'd7,  3'd6, 2'd2, 8'h41, 8'h00, 3'b000, 10'h040, 3'b100}, // R7 queued error
    {4'd11, 3'd0, 2'd0, 8'h80, 8'h00, 3'b110, 10'h080, 3'b001}, // R11 dma over hsm/tmo
    {4'd9,  3'd5, 2'd0, 8'h40, 8'h00, 3'b011, 10'h100, 3'b001}, // R9 late
    {4'd9,  3'd5, 2'd0, 8'h40, 8'h00, 3'b010, 10'h200, 3'b011}, // R9 unknown
    {4'd11, 3'd0, 2'd0, 8'h80, 8'h00, 3'b010, 10'h001, 3'b011}, // R11 hsm over tmo
    {4'd11, 3'd5, 2'd0, 8'h41, 8'h40, 3'b010, 10'h200, 3'b011}, // R11 tmo over device
    {4'd5,  3'd5, 2'd1, 8'h41, 8'h00, 3'b000, 10'h004, 3'b000}  // R5 packet completion
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [40:0] v);
    phase_i = v[36:34]; cmd_kind_i = v[33:32]; status_i = v[31:24]; error_i = v[23:16];
    dma_err_i = v[15]; tmo_i = v[14]; late_done_i = v[13];
  endtask

  function automatic logic [2:0] flags();
    return {fetch_log_o, xport_suspect_o, reset_req_o};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_i = 0; ack_i = 0;
    drive(41'd0);
    repeat (3) @(negedge clk);
    chk(1, cat_o, 0, "category in reset");       // R1
    chk(1, flags(), 0, "hints in reset");        // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1, cat_o, 0, "category after reset");    // R1

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      sample_i = 1'b1;
      @(negedge clk);
      sample_i = 1'b0;
      chk(int'(VEC[i][40:37]), cat_o, VEC[i][12:3], $sformatf("vec %0d category", i));
      chk(int'(VEC[i][40:37]), flags(), VEC[i][2:0], $sformatf("vec %0d hints", i));
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      chk(12, cat_o, 0, $sformatf("vec %0d cleared by ack", i)); // R12
    end

    // R12: capture timing and hold against a second strobe
    drive({4'd0, 3'd0, 2'd0, 8'h80, 8'h00, 3'b000, 13'd0});
    sample_i = 1'b1;
    #1 chk(12, cat_o, 0, "no output before edge");
    @(negedge clk);
    drive({4'd0, 3'd6, 2'd2, 8'h41, 8'h00, 3'b100, 13'd0});
    @(negedge clk);
    sample_i = 1'b0;
    chk(12, cat_o, 10'h001, "held against new strobe");
    chk(12, flags(), 3'b011, "held hints");
    // R12: strobe in same cycle as ack is dropped
    sample_i = 1'b1; ack_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0; ack_i = 1'b0;
    chk(12, cat_o, 0, "ack wins over strobe");
    @(negedge clk);
    chk(12, cat_o, 0, "stays clear after ack");
    // R12: ack without held result does nothing harmful
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(12, cat_o, 0, "idle ack");

    // R13: reserved phase quiet, but timeout still reported
    drive({4'd0, 3'd7, 2'd0, 8'h49, 8'hFF, 3'b000, 13'd0});
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    chk(13, cat_o, 0, "reserved phase quiet");
    drive({4'd0, 3'd7, 2'd0, 8'h49, 8'hFF, 3'b010, 13'd0});
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    chk(13, cat_o, 10'h200, "reserved phase timeout");
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;

    // R1: asynchronous reset clears a held result
    drive({4'd0, 3'd6, 2'd2, 8'h41, 8'h00, 3'b000, 13'd0});
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    chk(7, fetch_log_o, 1, "fetch before reset");
    rst_n = 1'b0;
    #1 chk(1, cat_o, 0, "async reset clears");
    chk(1, flags(), 0, "async reset hints");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule